// File: doc/BRIEF.md
# GPIO Bank Register Controller

This block holds the control state for one bank of general purpose pins, up to 32 of them. It has a single word-wide synchronous register bus. Software uses the bus to configure which pins are driven and the levels they drive, and to sample the levels present on the pads. The output-enable and output-level registers can be rewritten whole. They can also be changed bit by bit through three alias addresses, which set, clear or flip only the bits written as one. Because of these aliases, two pieces of software can each change their own pins without a read-modify-write sequence.

Every pin has a two-bit function code. The GPIO registers reach the pad only when that code equals 3. With any other code, the block presents an enable of zero and a level of zero for that pin, so another function can own the pad. The pad levels always pass through a two-flop synchronizer into the input register. That register shows the synchronized levels whatever the function codes and the enables are.

Bus address map, by byte address: bits [7:4] select the register and bits [3:2] select the access kind. Bits [1:0] are ignored. Register index 0 is output enable. Index 1 is output level. Index 2 is the input register. Indices 3 and up are the function-code words. Access kind 0 is a plain write, 1 is set, 2 is clear and 3 is toggle.

Top module: `gpio_bank`

## Requirements
- R1: A write with access kind 0 (address offset 0x0 within a register) replaces the output-enable register (index 0) or the output-level register (index 1). The new value reads back from that register's base address.
- R2: A write with access kind 1 (offset 0x4) turns on every register bit whose write-data bit is one and leaves all other bits unchanged.
- R3: A write with access kind 2 (offset 0x8) turns off every register bit whose write-data bit is one and leaves all other bits unchanged.
- R4: A write with access kind 3 (offset 0xC) inverts every register bit whose write-data bit is one and leaves all other bits unchanged.
- R5: A read from any of the set, clear or toggle offsets returns the current value of the register at the base offset.
- R6: pin_oe[p] and pin_out[p] follow bit p of the output-enable and output-level registers only while the function code of pin p is 3. For any other code, both outputs are 0.
- R7: After reset the output-enable and output-level registers are zero, so no pin is driven, and every function code reads 3. pin_oe stays zero while reset is held.
- R8: The input register (index 2, address 0x20) returns pin_in delayed by a two-flop synchronizer. A level applied before clock edge k is captured in a read issued after edge k+1, and not in a read issued before it. This holds whatever the function codes and enables are.
- R9: Register bits at or above PIN_COUNT read as zero, and writes to them do not store.
- R10: Writes to any of the four input-register addresses (0x20 to 0x2C) change no register.
- R11: The function code of pin p is the bit pair [2(p mod 16)+1 : 2(p mod 16)] of function word p/16. Word w sits at register index 3+w (address 0x30 for word 0 and 0x40 for word 1), and the four access kinds apply to it as well.
- R12: Read data is registered. It shows the register addressed in one cycle after the next rising edge. Unused register indices read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: [7:4] register index, [3:2] access kind |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pin_in | input | PIN_COUNT | Pad input levels, asynchronous to clk |
| pin_oe | output | PIN_COUNT | Pad driver enable for each pin |
| pin_out | output | PIN_COUNT | Pad output level for each pin |

## Verification
The assertions check on every cycle that each write kind has its effect on the output-enable register, that no non-GPIO pin is ever enabled or driven, that reserved read bits stay zero, and that the input register lags the pins by exactly two edges. Other behaviour appears only in the bench's scenarios. This covers alias reads returning the base value, writes to the input addresses having no effect, the function-code bit layout across both words, the reset values, and the exact cycle in which a pad change first appears on a read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned IDX_OE    = 0;
    localparam int unsigned IDX_DOUT  = 1;
    localparam int unsigned IDX_DIN   = 2;
    localparam int unsigned IDX_FSEL0 = 3;
    localparam logic [1:0]  FUNC_GPIO = 2'd3;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_state_t;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int unsigned    WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  alias_op_e        op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE:  value_d = wdata;
                OP_SET:    value_d = value_q | wdata;
                OP_CLEAR:  value_d = value_q & ~wdata;
                OP_TOGGLE: value_d = value_q ^ wdata;
                default:   value_d = value_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= RESET_VAL;
        else        value_q <= value_d;
    end

    assign value = value_q;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PIN_COUNT   = 21,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] pin_out
);

    localparam int unsigned FSEL_BITS  = 2 * PIN_COUNT;
    localparam int unsigned FSEL_WORDS = (FSEL_BITS + BUS_W - 1) / BUS_W;

    logic [3:0]           reg_idx;
    alias_op_e            acc_op;
    logic                 unused_addr_bits;
    logic [PIN_COUNT-1:0] oe_val, dout_val, din_val, gpio_en;
    logic [FSEL_BITS-1:0] fsel_flat;
    logic [BUS_W-1:0]     fsel_word [FSEL_WORDS];
    rd_state_t            st_d, st_q;

    assign reg_idx          = bus_addr[7:4];
    assign acc_op           = alias_op_e'(bus_addr[3:2]);
    assign unused_addr_bits = ^bus_addr[1:0];

    gpio_alias_reg #(.WIDTH(PIN_COUNT), .RESET_VAL('0)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && (reg_idx == 4'(IDX_OE))),
        .op    (acc_op),
        .wdata (bus_wdata[PIN_COUNT-1:0]),
        .value (oe_val)
    );

    gpio_alias_reg #(.WIDTH(PIN_COUNT), .RESET_VAL('0)) u_dout (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_we && (reg_idx == 4'(IDX_DOUT))),
        .op    (acc_op),
        .wdata (bus_wdata[PIN_COUNT-1:0]),
        .value (dout_val)
    );

    generate
        for (genvar w = 0; w < FSEL_WORDS; w++) begin : g_fsel
            localparam int unsigned LO = BUS_W * w;
            localparam int unsigned WW = ((FSEL_BITS - LO) > BUS_W) ? BUS_W : (FSEL_BITS - LO);
            logic [WW-1:0] word_val;

            gpio_alias_reg #(.WIDTH(WW), .RESET_VAL('1)) u_word (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (bus_we && (reg_idx == 4'(IDX_FSEL0 + w))),
                .op    (acc_op),
                .wdata (bus_wdata[WW-1:0]),
                .value (word_val)
            );

            assign fsel_flat[LO +: WW] = word_val;
            assign fsel_word[w]        = BUS_W'(word_val);
        end

        for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
            assign gpio_en[p] = (fsel_flat[2*p +: 2] == FUNC_GPIO);
        end
    endgenerate

    gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (din_val)
    );

    assign pin_oe  = oe_val & gpio_en;
    assign pin_out = dout_val & gpio_en;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (reg_idx == 4'(IDX_OE))        st_d.rdata = BUS_W'(oe_val);
        else if (reg_idx == 4'(IDX_DOUT)) st_d.rdata = BUS_W'(dout_val);
        else if (reg_idx == 4'(IDX_DIN))  st_d.rdata = BUS_W'(din_val);
        else begin
            for (int w = 0; w < FSEL_WORDS; w++) begin
                if (reg_idx == 4'(IDX_FSEL0 + w)) st_d.rdata = fsel_word[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 21
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [BUS_W-1:0]       bus_wdata,
    input logic [BUS_W-1:0]       bus_rdata,
    input logic [PIN_COUNT-1:0]   pin_in,
    input logic [PIN_COUNT-1:0]   pin_oe,
    input logic [PIN_COUNT-1:0]   pin_out,
    input logic [PIN_COUNT-1:0]   oe_val,
    input logic [PIN_COUNT-1:0]   din_val,
    input logic [2*PIN_COUNT-1:0] fsel_flat
);

    logic [PIN_COUNT-1:0] wd_m, gpio_m;
    logic                 oe_hit;
    logic [1:0]           since_rst;

    assign wd_m   = bus_wdata[PIN_COUNT-1:0];
    assign oe_hit = bus_we && (bus_addr[7:4] == 4'(IDX_OE));

    generate
        for (genvar p = 0; p < PIN_COUNT; p++) begin : g_mask
            assign gpio_m[p] = fsel_flat[2*p] & fsel_flat[2*p+1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
    end

    a_r7_reset_no_drive: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_oe == '0));

    a_r1_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hit && bus_addr[3:2] == 2'd0) |=> (oe_val == $past(wd_m)));

    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hit && bus_addr[3:2] == 2'd1) |=> ((oe_val & $past(wd_m)) == $past(wd_m)));

    a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hit && bus_addr[3:2] == 2'd2) |=> ((oe_val & $past(wd_m)) == '0));

    a_r4_toggle_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_hit && bus_addr[3:2] == 2'd3) |=> (oe_val == ($past(oe_val) ^ $past(wd_m))));

    a_r6_no_foreign_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~gpio_m) == '0) && ((pin_out & ~gpio_m) == '0));

    a_r6_gpio_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_oe ^ oe_val) & gpio_m) == '0));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_addr[7:4]) <= 4'd2) |-> ((bus_rdata >> PIN_COUNT) == '0));

    a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (din_val == $past(pin_in, 2)));

endmodule

bind gpio_bank gpio_bank_chk #(.PIN_COUNT(PIN_COUNT)) u_gpio_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .oe_val    (oe_val),
    .din_val   (din_val),
    .fsel_flat (fsel_flat)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

    localparam int unsigned PINS = 21;
    localparam logic [31:0] PMASK = (32'd1 << PINS) - 32'd1;
    localparam logic [31:0] W1MASK = 32'h3FF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_oe, pin_out;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 1'b0;

    logic        rd_req = 1'b0;
    logic        rd_vld = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    logic [31:0] oe_m = '0, dout_m = '0, din_m = '0;
    logic [63:0] fsel_m = {22'd0, 42'h3FF_FFFF_FFFF};

    always #2.5 clk = ~clk;

    gpio_bank #(.PIN_COUNT(PINS)) i_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(input logic [31:0] cur, input int op,
                                          input logic [31:0] d, input logic [31:0] m);
        logic [31:0] r;
        case (op)
            0:       r = d;
            1:       r = cur | d;
            2:       r = cur & ~d;
            default: r = cur ^ d;
        endcase
        return r & m;
    endfunction

    function automatic logic [31:0] model_val(input int idx);
        case (idx)
            0:       return oe_m;
            1:       return dout_m;
            2:       return din_m;
            3:       return fsel_m[31:0];
            4:       return fsel_m[63:32];
            default: return 32'd0;
        endcase
    endfunction

    // scoreboard monitor: a read captured at a rising edge is compared at the following falling edge
    always @(posedge clk) rd_vld <= rd_req;

    always @(negedge clk) begin
        if (rd_vld && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
        end
    end

    task automatic wr(input int idx, input int op, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = {idx[3:0], op[1:0], 2'b00};
        bus_we    = 1'b1;
        bus_wdata = d;
        rd_req    = 1'b0;
        case (idx)
            0: oe_m   = apply(oe_m, op, d, PMASK);
            1: dout_m = apply(dout_m, op, d, PMASK);
            3: fsel_m[31:0]  = apply(fsel_m[31:0], op, d, 32'hFFFF_FFFF);
            4: fsel_m[63:32] = apply(fsel_m[63:32], op, d, W1MASK);
            default: ;
        endcase
    endtask

    task automatic rd(input int idx, input int op, input string tag);
        @(negedge clk);
        bus_addr = {idx[3:0], op[1:0], 2'b00};
        bus_we   = 1'b0;
        rd_req   = 1'b1;
        exp_q.push_back(model_val(idx));
        tag_q.push_back(tag);
    endtask

    task automatic check_pins(input string tag);
        logic [31:0] g;
        @(negedge clk);
        bus_we = 1'b0;
        rd_req = 1'b0;
        g = '0;
        for (int p = 0; p < PINS; p++) g[p] = (fsel_m[2*p +: 2] == 2'd3);
        check({tag, " oe"},  32'(pin_oe),  oe_m & g);
        check({tag, " out"}, 32'(pin_out), dout_m & g);
    endtask

    task automatic pin_step(input logic [PINS-1:0] v);
        @(negedge clk);
        pin_in   = v;
        bus_addr = 8'h20;
        bus_we   = 1'b0;
        rd_req   = 1'b1;
        exp_q.push_back(din_m);
        tag_q.push_back("R8 same-edge read shows old level");
        rd(2, 0, "R8 one edge later still old");
        din_m = 32'(v);
        rd(2, 0, "R8 two edges later shows new level");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pin_oe !== '0) begin
            errors++;
            $display("FAIL R7: actual=%h expected=0 during reset", pin_oe);
        end
        rst_n = 1'b1;

        // R7 / R11 reset values
        rd(0, 0, "R7 enable resets to zero");
        rd(1, 0, "R7 level resets to zero");
        rd(3, 0, "R7 R11 function word 0 resets to all 3");
        rd(4, 0, "R7 R11 function word 1 resets to all 3");
        check_pins("R7 no pin driven after reset");

        // R1 / R9 plain writes
        wr(0, 0, 32'hFFFF_FFFF);
        rd(0, 0, "R1 R9 enable full write, reserved bits zero");
        wr(0, 0, 32'h0000_A5A5);
        rd(0, 0, "R1 enable plain write");
        wr(1, 0, 32'h001F_0F0F);
        rd(1, 0, "R1 level plain write");

        // R2 R3 R4 R5 aliases on both registers
        wr(0, 1, 32'hFFF0_0003);
        rd(0, 0, "R2 enable set alias");
        wr(0, 2, 32'h0010_0021);
        rd(0, 0, "R3 enable clear alias");
        wr(0, 3, 32'h0000_FFFF);
        rd(0, 0, "R4 enable toggle alias");
        rd(0, 1, "R5 read via set offset");
        rd(0, 2, "R5 read via clear offset");
        rd(0, 3, "R5 read via toggle offset");
        wr(1, 1, 32'h0000_00F0);
        wr(1, 2, 32'h0000_000F);
        wr(1, 3, 32'h0010_0101);
        rd(1, 0, "R2 R3 R4 level alias sequence");
        rd(1, 3, "R5 level read via toggle offset");

        // R6 gating by function code
        check_pins("R6 all pins GPIO");
        wr(3, 0, 32'h0000_0000);
        check_pins("R6 pins 0-15 given away");
        wr(3, 0, 32'hFFFF_FFBF);
        rd(3, 0, "R11 pin 3 code in bits 7:6");
        check_pins("R6 R11 pin 3 code 2 not GPIO");
        wr(4, 2, 32'h0000_0003);
        rd(4, 0, "R11 word 1 clear alias, pin 16 bits 1:0");
        check_pins("R6 R11 pin 16 code 0 not GPIO");
        wr(4, 1, 32'hFFFF_FFFF);
        rd(4, 0, "R9 R11 word 1 reserved bits zero");

        // R8 input path, independent of function code and enable
        wr(3, 0, 32'h0000_0000);
        wr(0, 0, 32'h001F_FFFF);
        pin_step(21'h1A5C3);
        pin_step(21'h05A3C);
        wr(0, 0, 32'h0);
        pin_step(21'h1FFFF);

        // R10 input register ignores writes
        wr(2, 0, 32'h0000_0000);
        wr(2, 1, 32'hFFFF_FFFF);
        wr(2, 2, 32'hFFFF_FFFF);
        wr(2, 3, 32'h1234_5678);
        rd(2, 0, "R10 input unchanged by writes");
        rd(0, 0, "R10 enable unchanged by input writes");
        rd(1, 0, "R10 level unchanged by input writes");

        // R12 unused indices and read timing
        rd(15, 0, "R12 unused index reads zero");
        rd(5, 2, "R12 index past function words reads zero");
        rd(1, 0, "R12 read follows address by one edge");

        @(negedge clk);
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule